// File: doc/BRIEF.md
# Critical-Word-First Cache Block Refill Controller

This controller services one cache miss at a time by refilling an eight-word cache block over a memory port that returns one word per beat. It takes a miss address and issues a single burst request to memory. As the beats come back, it writes each word into the cache line. The CPU is released as soon as the word it missed on has arrived, without waiting for the whole block. The rest of the block keeps filling while the CPU runs.

A mode input chooses the fill order for each miss. In the in-order mode the burst starts at word zero, and the CPU restarts whenever its word happens to arrive. In the wrapped mode the burst starts at the missed word and continues through the block modulo eight, so the CPU restarts after the first beat.

While a fill is in progress, a CPU access to the same block is answered from the words already written. If the word it wants has not yet arrived, the access stalls. The line is marked valid only once the last word is in place. A new miss is not taken until the current fill has finished.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: After reset, `miss_ready` is 1 and `mem_req_valid`, `line_we`, `cpu_restart`, `line_valid`, `acc_ack` and `acc_stall` are 0.
- R2: A miss is taken on a clock edge where `miss_valid` and `miss_ready` are both 1. From the next cycle, `mem_req_valid` is 1 with `mem_req_addr` = {block, start word, two zero byte bits}, where the word offset is address bits [4:2] and the block is bits [31:5]. The request and its address are held until the edge on which `mem_req_ready` is 1, after which the request is dropped.
- R3: With `wrap_mode` = 0, the eight beats are written to line word indices 0, 1, ..., 7 in that order.
- R4: With `wrap_mode` = 1, the first beat is written to the missed word index, and each following beat to the next index modulo 8.
- R5: Each beat that arrives with `mem_beat_valid` = 1 is written one cycle later: `line_we` = 1, `line_idx` = the word index of that beat, `line_wdata` = the beat data, and `line_blk` = the miss block.
- R6: Each fill gives exactly one `cpu_restart` pulse. It comes in the cycle in which the missed word is written, with `cpu_rdata` equal to that word, and in the in-order mode this can fall in the middle of the fill.
- R7: `line_valid` pulses for one cycle, exactly one cycle after the last word write of the fill. It is never high at any other time.
- R8: From the cycle after a miss is taken until the cycle in which `line_valid` pulses, `miss_ready` is 0. A `miss_valid` asserted during that window starts no new memory request.
- R9: During a fill, an access (`acc_valid` = 1) to the filling block whose word has already been written gives `acc_ack` = 1, `acc_stall` = 0 and `acc_rdata` = that word, in the same cycle.
- R10: During a fill, an access to the filling block whose word has not yet been written gives `acc_stall` = 1 and `acc_ack` = 0.
- R11: An access to a different block, or any access while no fill is in progress, gives neither `acc_ack` nor `acc_stall`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrap_mode | input | 1 | 1 = start at the missed word and wrap; 0 = start at word 0 |
| miss_valid | input | 1 | Miss request present |
| miss_addr | input | 32 | Byte address of the missed word |
| miss_ready | output | 1 | Controller is idle and can take a miss |
| mem_req_valid | output | 1 | Burst request to memory |
| mem_req_addr | output | 32 | Address of the first beat of the burst |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_beat_valid | input | 1 | A returned word is present |
| mem_beat_data | input | 32 | Returned word |
| line_we | output | 1 | Cache line word write strobe |
| line_blk | output | 27 | Block address being filled |
| line_idx | output | 3 | Word index within the line |
| line_wdata | output | 32 | Word being written |
| line_valid | output | 1 | One-cycle pulse: set the line valid bit |
| cpu_restart | output | 1 | One-cycle pulse: missed word delivered, CPU may resume |
| cpu_rdata | output | 32 | Missed word returned to the CPU |
| acc_valid | input | 1 | CPU access probe during a fill |
| acc_addr | input | 32 | Byte address of the access |
| acc_ack | output | 1 | Access served from the partly filled line |
| acc_stall | output | 1 | Access must wait for its word |
| acc_rdata | output | 32 | Word returned for a served access |

## Verification
The in-RTL properties check several relations on every cycle:
- the restart pulse always lands on the write of the missed word;
- the valid pulse directly follows a write and never overlaps one;
- a memory request only starts from an accepted miss, and is held steady until taken;
- the beat offset wraps from 7 to 0 and starts at the loaded start word;
- a written word is marked as present in the following cycle.

Only the bench scenarios can show the following:
- the full write order for each mode and missed offset, including an offset of 7, which wraps at once;
- that exactly one restart and one valid pulse occur per fill;
- that stalls turn into acknowledgements as beats arrive with gaps between them;
- that misses presented during a fill are ignored.

// File: rtl/cwf_refill_pkg.sv
package cwf_refill_pkg;

    // Controller phases of one block refill
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_FILL  = 2'd2,
        ST_CLOSE = 2'd3
    } fill_state_e;

endpackage

// File: rtl/cwf_beat_seq.sv
// Tracks the word index carried by each beat of a burst and the beat count.
module cwf_beat_seq #(
    parameter int WORDS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [$clog2(WORDS)-1:0] start_off,
    input  logic                     step,
    output logic [$clog2(WORDS)-1:0] off,
    output logic                     is_last
);
    localparam int OFF_W = $clog2(WORDS);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic [OFF_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (load) begin
            seq_d.off = start_off;
            seq_d.cnt = '0;
        end else if (step) begin
            seq_d.off = (seq_q.off == LAST_OFF) ? '0 : seq_q.off + 1'b1;
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign off     = seq_q.off;
    assign is_last = (seq_q.cnt == LAST_OFF);

    // R4
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && off == LAST_OFF) |=> (off == '0));

    // R4
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (off == $past(start_off)));

endmodule

// File: rtl/cwf_line_buf.sv
// Shadow copy of the line being filled, with a per-word arrival mask.
module cwf_line_buf #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     wr_en,
    input  logic [$clog2(WORDS)-1:0] wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(WORDS)-1:0] rd_idx,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_present
);
    typedef struct packed {
        logic [WORDS-1:0]             mask;
        logic [WORDS-1:0][DATA_W-1:0] words;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (clear) begin
            buf_d.mask = '0;
        end
        if (wr_en) begin
            buf_d.mask[wr_idx]  = 1'b1;
            buf_d.words[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign rd_data    = buf_q.words[rd_idx];
    assign rd_present = buf_q.mask[rd_idx];

    // R9
    word_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> buf_q.mask[$past(wr_idx)]);

    // R10
    mask_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !wr_en) |=> (buf_q.mask == '0));

endmodule

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl
    import cwf_refill_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 8
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic                                                wrap_mode,
    input  logic                                                miss_valid,
    input  logic [ADDR_W-1:0]                                   miss_addr,
    output logic                                                miss_ready,
    output logic                                                mem_req_valid,
    output logic [ADDR_W-1:0]                                   mem_req_addr,
    input  logic                                                mem_req_ready,
    input  logic                                                mem_beat_valid,
    input  logic [DATA_W-1:0]                                   mem_beat_data,
    output logic                                                line_we,
    output logic [ADDR_W-$clog2(WORDS)-$clog2(DATA_W/8)-1:0]    line_blk,
    output logic [$clog2(WORDS)-1:0]                            line_idx,
    output logic [DATA_W-1:0]                                   line_wdata,
    output logic                                                line_valid,
    output logic                                                cpu_restart,
    output logic [DATA_W-1:0]                                   cpu_rdata,
    input  logic                                                acc_valid,
    input  logic [ADDR_W-1:0]                                   acc_addr,
    output logic                                                acc_ack,
    output logic                                                acc_stall,
    output logic [DATA_W-1:0]                                   acc_rdata
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int BLK_W  = ADDR_W - OFF_W - BYTE_W;

    typedef struct packed {
        fill_state_e      state;
        logic [BLK_W-1:0] blk;
        logic [OFF_W-1:0] crit;
        logic [OFF_W-1:0] start;
        logic             we;
        logic [OFF_W-1:0] widx;
        logic [DATA_W-1:0] wdata;
        logic             restart;
        logic [DATA_W-1:0] rdata;
        logic             valid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              seq_load, seq_step, seq_last;
    logic [OFF_W-1:0]  seq_off;
    logic              buf_clear, buf_we, buf_present;
    logic [DATA_W-1:0] buf_rdata;
    logic              acc_in_fill;
    logic              unused_byte_bits;

    assign unused_byte_bits = ^{miss_addr[BYTE_W-1:0], acc_addr[BYTE_W-1:0]};

    cwf_beat_seq #(.WORDS(WORDS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (seq_load),
        .start_off (ctl_q.start),
        .step      (seq_step),
        .off       (seq_off),
        .is_last   (seq_last)
    );

    cwf_line_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (buf_clear),
        .wr_en      (buf_we),
        .wr_idx     (seq_off),
        .wr_data    (mem_beat_data),
        .rd_idx     (acc_addr[BYTE_W +: OFF_W]),
        .rd_data    (buf_rdata),
        .rd_present (buf_present)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.we      = 1'b0;
        ctl_d.restart = 1'b0;
        ctl_d.valid   = 1'b0;
        seq_load      = 1'b0;
        seq_step      = 1'b0;
        buf_clear     = 1'b0;
        buf_we        = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (miss_valid) begin
                    ctl_d.blk   = miss_addr[ADDR_W-1 -: BLK_W];
                    ctl_d.crit  = miss_addr[BYTE_W +: OFF_W];
                    ctl_d.start = wrap_mode ? miss_addr[BYTE_W +: OFF_W] : '0;
                    ctl_d.state = ST_REQ;
                    buf_clear   = 1'b1;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    seq_load    = 1'b1;
                    ctl_d.state = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_beat_valid) begin
                    buf_we      = 1'b1;
                    seq_step    = 1'b1;
                    ctl_d.we    = 1'b1;
                    ctl_d.widx  = seq_off;
                    ctl_d.wdata = mem_beat_data;
                    if (seq_off == ctl_q.crit) begin
                        ctl_d.restart = 1'b1;
                        ctl_d.rdata   = mem_beat_data;
                    end
                    if (seq_last) begin
                        ctl_d.state = ST_CLOSE;
                    end
                end
            end
            ST_CLOSE: begin
                ctl_d.valid = 1'b1;
                ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign miss_ready    = (ctl_q.state == ST_IDLE);
    assign mem_req_valid = (ctl_q.state == ST_REQ);
    assign mem_req_addr  = {ctl_q.blk, ctl_q.start, {BYTE_W{1'b0}}};

    assign line_we     = ctl_q.we;
    assign line_blk    = ctl_q.blk;
    assign line_idx    = ctl_q.widx;
    assign line_wdata  = ctl_q.wdata;
    assign line_valid  = ctl_q.valid;
    assign cpu_restart = ctl_q.restart;
    assign cpu_rdata   = ctl_q.rdata;

    assign acc_in_fill = acc_valid && (ctl_q.state != ST_IDLE)
                         && (acc_addr[ADDR_W-1 -: BLK_W] == ctl_q.blk);
    assign acc_ack     = acc_in_fill && buf_present;
    assign acc_stall   = acc_in_fill && !buf_present;
    assign acc_rdata   = buf_rdata;

    // R6
    restart_on_crit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_restart |-> (line_we && line_idx == ctl_q.crit && cpu_rdata == line_wdata));

    // R7
    valid_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> ($past(line_we) && !line_we));

    // R8
    req_from_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(miss_valid && miss_ready));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10
    ack_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_ack && acc_stall));

endmodule

// File: tb/cwf_refill_ctrl_test.sv
module cwf_refill_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wrap_mode, miss_valid, miss_ready;
    logic [31:0] miss_addr;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_beat_valid;
    logic [31:0] mem_beat_data;
    logic        line_we, line_valid, cpu_restart;
    logic [26:0] line_blk;
    logic [2:0]  line_idx;
    logic [31:0] line_wdata, cpu_rdata;
    logic        acc_valid, acc_ack, acc_stall;
    logic [31:0] acc_addr, acc_rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cwf_refill_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wrap_mode(wrap_mode),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
        .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data),
        .line_we(line_we), .line_blk(line_blk), .line_idx(line_idx), .line_wdata(line_wdata),
        .line_valid(line_valid), .cpu_restart(cpu_restart), .cpu_rdata(cpu_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_ack(acc_ack),
        .acc_stall(acc_stall), .acc_rdata(acc_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int restarts_seen, valids_seen;
    logic [2:0]  q_idx[$];
    logic [31:0] q_dat[$];
    logic [26:0] exp_blk;
    logic [2:0]  exp_crit;
    logic [31:0] exp_crit_data;
    string       order_tag = "R3";

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input logic [26:0] b, input logic [2:0] i);
        return {b[23:0], 5'b0, i} ^ 32'hC3A5_0F00;
    endfunction

    // Monitor: pops the scoreboard as the design writes the line
    always @(negedge clk) begin
        if (rst_n) begin
            if (line_we) begin
                if (q_idx.size() == 0) begin
                    chk(1'b0, "R5 unexpected write", {29'b0, line_idx}, 32'hFFFF_FFFF);
                end else begin
                    logic [2:0]  e_i;
                    logic [31:0] e_d;
                    e_i = q_idx.pop_front();
                    e_d = q_dat.pop_front();
                    chk(line_idx == e_i, order_tag, {29'b0, line_idx}, {29'b0, e_i});
                    chk(line_wdata == e_d, "R5 data", line_wdata, e_d);
                    chk(line_blk == exp_blk, "R5 block", {5'b0, line_blk}, {5'b0, exp_blk});
                end
            end
            if (cpu_restart) begin
                restarts_seen++;
                chk(line_we && line_idx == exp_crit, "R6 restart word", {29'b0, line_idx}, {29'b0, exp_crit});
                chk(cpu_rdata == exp_crit_data, "R6 restart data", cpu_rdata, exp_crit_data);
            end
            if (line_valid) begin
                valids_seen++;
                chk(q_idx.size() == 0, "R7 valid before last", q_idx.size(), 0);
            end
        end
    end

    task automatic probe(input logic [31:0] a, input bit e_ack, input bit e_stall,
                         input logic [31:0] e_dat, input string tag);
        acc_valid = 1'b1;
        acc_addr  = a;
        #1;
        chk(acc_ack == e_ack, tag, {31'b0, acc_ack}, {31'b0, e_ack});
        chk(acc_stall == e_stall, tag, {31'b0, acc_stall}, {31'b0, e_stall});
        if (e_ack) chk(acc_rdata == e_dat, tag, acc_rdata, e_dat);
        acc_valid = 1'b0;
    endtask

    task automatic do_miss(input logic [31:0] addr, input bit cwf, input int req_delay, input int gap);
        logic [26:0] blk;
        logic [2:0]  crit, start;
        blk   = addr[31:5];
        crit  = addr[4:2];
        start = cwf ? crit : 3'd0;
        restarts_seen = 0;
        valids_seen   = 0;
        exp_blk       = blk;
        exp_crit      = crit;
        exp_crit_data = pat(blk, crit);
        order_tag     = cwf ? "R4 wrapped order" : "R3 block order";

        @(negedge clk);
        wrap_mode  = cwf;
        miss_addr  = addr;
        miss_valid = 1'b1;
        #1 chk(miss_ready == 1'b1, "R2 ready idle", {31'b0, miss_ready}, 1);
        @(negedge clk);
        miss_valid = 1'b0;
        chk(mem_req_valid == 1'b1, "R2 request", {31'b0, mem_req_valid}, 1);
        chk(mem_req_addr == {blk, start, 2'b00}, "R2 request addr", mem_req_addr, {blk, start, 2'b00});
        chk(miss_ready == 1'b0, "R8 busy", {31'b0, miss_ready}, 0);
        repeat (req_delay) begin
            @(negedge clk);
            chk(mem_req_valid == 1'b1 && mem_req_addr == {blk, start, 2'b00}, "R2 request held",
                mem_req_addr, {blk, start, 2'b00});
        end
        mem_req_ready = 1'b1;
        for (int k = 0; k < 8; k++) begin
            q_idx.push_back(3'(start + k));
            q_dat.push_back(pat(blk, 3'(start + k)));
        end
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(mem_req_valid == 1'b0, "R2 request dropped", {31'b0, mem_req_valid}, 0);

        for (int k = 0; k < 8; k++) begin
            logic [2:0] cur;
            cur = 3'(start + k);
            if (k > 0) begin
                logic [2:0] prev;
                prev = 3'(start + k - 1);
                probe({blk, prev, 2'b00}, 1'b1, 1'b0, pat(blk, prev), "R9 written word");
            end
            probe({blk, cur, 2'b01}, 1'b0, 1'b1, 32'h0, "R10 pending word");
            probe({blk ^ 27'h0000_100, cur, 2'b00}, 1'b0, 1'b0, 32'h0, "R11 other block");
            mem_beat_valid = 1'b1;
            mem_beat_data  = pat(blk, cur);
            @(negedge clk);
            mem_beat_valid = 1'b0;
            if (k < 7) begin
                repeat (gap) begin
                    miss_valid = 1'b1;
                    miss_addr  = addr ^ 32'h0000_1000;
                    #1 chk(miss_ready == 1'b0, "R8 miss refused", {31'b0, miss_ready}, 0);
                    @(negedge clk);
                end
                miss_valid = 1'b0;
            end
        end
        // now one negedge after the last beat: last write visible this cycle
        chk(line_valid == 1'b0, "R7 not with last write", {31'b0, line_valid}, 0);
        chk(miss_ready == 1'b0, "R8 busy at last write", {31'b0, miss_ready}, 0);
        @(negedge clk);
        chk(line_valid == 1'b1, "R7 valid pulse", {31'b0, line_valid}, 1);
        chk(miss_ready == 1'b1, "R8 ready after fill", {31'b0, miss_ready}, 1);
        chk(mem_req_valid == 1'b0, "R8 no stray request", {31'b0, mem_req_valid}, 0);
        @(negedge clk);
        chk(line_valid == 1'b0, "R7 single pulse", {31'b0, line_valid}, 0);
        chk(restarts_seen == 1, "R6 one restart", restarts_seen, 1);
        chk(valids_seen == 1, "R7 one valid", valids_seen, 1);
        chk(q_idx.size() == 0, "R5 all beats written", q_idx.size(), 0);
        probe({blk, crit, 2'b00}, 1'b0, 1'b0, 32'h0, "R11 idle access");
    endtask

    task automatic run_tests();
        @(negedge clk);
        chk(miss_ready == 1'b1, "R1 ready", {31'b0, miss_ready}, 1);
        chk(mem_req_valid == 1'b0, "R1 request", {31'b0, mem_req_valid}, 0);
        chk(line_we == 1'b0 && line_valid == 1'b0, "R1 line", {30'b0, line_we, line_valid}, 0);
        chk(cpu_restart == 1'b0, "R1 restart", {31'b0, cpu_restart}, 0);
        probe(32'h0, 1'b0, 1'b0, 32'h0, "R1 access idle");
        do_miss(32'h0000_1234, 1'b0, 0, 0);  // block order, missed word 5 mid-fill
        do_miss(32'h0000_225C, 1'b1, 2, 1);  // wrapped, missed word 7 wraps at once
        do_miss(32'hABCD_008C, 1'b1, 0, 2);  // wrapped, missed word 3 with beat gaps
        do_miss(32'h0000_4000, 1'b0, 1, 0);  // block order, missed word 0
        do_miss(32'h7777_7760, 1'b1, 0, 1);  // wrapped, missed word 0
        do_miss(32'h0000_1238, 1'b0, 0, 1);  // block order, missed word 6
    endtask

    initial begin
        rst_n          = 1'b0;
        wrap_mode      = 1'b0;
        miss_valid     = 1'b0;
        miss_addr      = '0;
        mem_req_ready  = 1'b0;
        mem_beat_valid = 1'b0;
        mem_beat_data  = '0;
        acc_valid      = 1'b0;
        acc_addr       = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            run_tests();
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog (all requirements): actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule